// File: doc/BRIEF.md
# Interpolated Output Spacing Scheduler

This block decides when output samples leave an interpolating filter chain. The chain has an optional resampler and two optional halfband stages. A three-bit stage-select field says which stages are active, and a bypass bit can skip the whole resampling section. From these two fields the block works out the interpolation ratio, which is 1, 2 or 4.

For every primary sample that the chain delivers, the block emits one primary output and then the extra interpolated outputs that the ratio calls for. Each output is marked with a strobe and an index. The extra outputs are separated by a programmed number of processing clocks. That number is normally the processing clock rate divided by the output rate, minus one.

Stage-select codes that name no legal stage combination are reported on an error flag, and so are spacing values that are too small. While the error flag is set, the block emits only primary outputs. A primary sample that arrives before the previous burst has finished ends that burst early, starts a new one, and sets a sticky overrun flag.

Top module: `ispace_sched`

## Requirements
- R1: When `cfg_bypass_i` is 0, the stage-select codes 3'b001, 3'b010, 3'b011, 3'b110 and 3'b111 are legal. The codes 3'b000, 3'b100 and 3'b101 set `cfg_err_o`.
- R2: When `cfg_bypass_i` is 1, the stage-select field is ignored. The ratio is 1 and the field never causes an error.
- R3: Bit 1 of the stage-select field enables the first halfband and bit 2 enables the second. Bit 0 enables the resampler and has no effect on the ratio. `ifactor_o` reports the ratio as the binary value 1, 2 or 4. An illegal code reports 1.
- R4: A primary strobe sampled at a clock edge produces `out_stb_o`=1 with `out_idx_o`=0 in the cycle that follows that edge.
- R5: At ratio 1 no extra outputs follow the primary. At ratio 2 one extra output follows, with index 1. At ratio 4 three extra outputs follow, with indices 1, 2 and 3 in that order.
- R6: Each extra output appears S+1 clock cycles after the output before it, where S is the value of `cfg_space_i`.
- R7: A spacing value below 2 sets `cfg_err_o`, whatever the stage-select field holds.
- R8: While `cfg_err_o` is set, a primary strobe still produces the index-0 output, but no extra outputs follow it.
- R9: A primary strobe that arrives while extra outputs are still pending cancels them. It starts a new burst from index 0 and sets `overrun_o`, which then stays 1 until reset.
- R10: `cfg_err_o` and `ifactor_o` follow the configuration inputs one cycle after they change. The spacing and ratio of a burst are captured at its primary strobe, so a spacing change made during a burst does not alter that burst.
- R11: After reset `out_stb_o`, `out_idx_o` and `overrun_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prim_stb_i | input | 1 | One-cycle strobe for each primary sample |
| cfg_bypass_i | input | 1 | 1 bypasses the resampling section |
| cfg_mode_i | input | 3 | Stage-select field |
| cfg_space_i | input | 8 | Clocks between outputs, minus one |
| out_stb_o | output | 1 | Output sample strobe |
| out_idx_o | output | 2 | Output index: 0 primary, 1 to 3 extra |
| ifactor_o | output | 3 | Current interpolation ratio (1, 2 or 4) |
| cfg_err_o | output | 1 | Illegal stage code or spacing |
| overrun_o | output | 1 | Sticky: a burst was cut short |

## Verification
The assertions take for granted that the primary strobe is high for a single cycle. They also assume that the configuration is stable for at least one cycle before a strobe, so that the captured ratio and the registered error flag agree. The spacing check assumes that a legal spacing of at least 2 keeps any two extra outputs from being adjacent. The directed stimulus keeps to these limits: it holds each strobe for exactly one cycle and sets the configuration several cycles before each strobe. The only change it makes during a burst is a spacing change that is itself legal.

// File: rtl/ispace_pkg.sv
package ispace_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [1:0] {
    IFAC_1 = 2'd0,
    IFAC_2 = 2'd1,
    IFAC_4 = 2'd2
  } ifac_e;

  function automatic logic [1:0] extras_of(input ifac_e f);
    case (f)
      IFAC_2:  extras_of = 2'd1;
      IFAC_4:  extras_of = 2'd3;
      default: extras_of = 2'd0;
    endcase
  endfunction

  function automatic logic [2:0] ratio_of(input ifac_e f);
    case (f)
      IFAC_2:  ratio_of = 3'd2;
      IFAC_4:  ratio_of = 3'd4;
      default: ratio_of = 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/ispace_cfg_dec.sv
module ispace_cfg_dec
  import ispace_pkg::*;
#(
  parameter int SPACE_W   = 8,
  parameter int MIN_SPACE = 2
) (
  input  logic                bypass_i,
  input  logic [MODE_W-1:0]   mode_i,
  input  logic [SPACE_W-1:0]  space_i,
  output ifac_e               ifac_o,
  output logic                mode_bad_o,
  output logic                space_bad_o
);

  localparam logic [SPACE_W-1:0] SPACE_MIN_V = SPACE_W'(MIN_SPACE);

  logic [1:0] hb_cnt;

  // Stage select: bit0 resampler, bit1 halfband one, bit2 halfband two
  always_comb begin
    mode_bad_o = 1'b0;
    hb_cnt     = 2'd0;
    if (!bypass_i) begin
      case (mode_i)
        3'b001:         hb_cnt = 2'd0;
        3'b010, 3'b011: hb_cnt = 2'd1;
        3'b110, 3'b111: hb_cnt = 2'd2;
        default: begin
          hb_cnt     = 2'd0;
          mode_bad_o = 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    case (hb_cnt)
      2'd1:    ifac_o = IFAC_2;
      2'd2:    ifac_o = IFAC_4;
      default: ifac_o = IFAC_1;
    endcase
  end

  assign space_bad_o = (space_i < SPACE_MIN_V);

endmodule

// File: rtl/ispace_gap_timer.sv
module ispace_gap_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         run_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_en = 1'b1;
      cnt_d  = load_val_i;
    end else if (run_i && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero_o = (cnt_q == '0);

  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && run_i && !zero_o) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R6
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !run_i) |=> $stable(cnt_q));

endmodule

// File: rtl/ispace_burst_ctrl.sv
module ispace_burst_ctrl #(
  parameter int SPACE_W = 8,
  parameter int IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prim_stb_i,
  input  logic [IDX_W-1:0]   extras_i,
  input  logic               err_i,
  input  logic [SPACE_W-1:0] space_i,
  input  logic               gap_zero_i,
  output logic               tmr_load_o,
  output logic [SPACE_W-1:0] tmr_val_o,
  output logic               tmr_run_o,
  output logic               out_stb_o,
  output logic [IDX_W-1:0]   out_idx_o,
  output logic               overrun_o
);

  logic [IDX_W-1:0]   left_q, left_d;
  logic [IDX_W-1:0]   nidx_q, nidx_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [SPACE_W-1:0] gap_q, gap_d;
  logic               stb_q, stb_d;
  logic               ovr_q, ovr_d;
  logic               pending;
  logic               fire_extra;

  assign pending    = (left_q != '0);
  assign fire_extra = pending && gap_zero_i && !prim_stb_i;

  always_comb begin
    left_d     = left_q;
    nidx_d     = nidx_q;
    gap_d      = gap_q;
    ovr_d      = ovr_q;
    stb_d      = 1'b0;
    idx_d      = '0;
    tmr_load_o = 1'b0;
    tmr_val_o  = gap_q;
    if (prim_stb_i) begin
      stb_d      = 1'b1;
      idx_d      = '0;
      nidx_d     = IDX_W'(1);
      left_d     = err_i ? '0 : extras_i;
      gap_d      = space_i;
      ovr_d      = ovr_q | pending;
      tmr_load_o = 1'b1;
      tmr_val_o  = space_i;
    end else if (fire_extra) begin
      stb_d      = 1'b1;
      idx_d      = nidx_q;
      nidx_d     = nidx_q + 1'b1;
      left_d     = left_q - 1'b1;
      tmr_load_o = 1'b1;
      tmr_val_o  = gap_q;
    end
  end

  assign tmr_run_o = pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      nidx_q <= '0;
      idx_q  <= '0;
      gap_q  <= '0;
      stb_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      stb_q <= stb_d;
      idx_q <= idx_d;
      ovr_q <= ovr_d;
      if (prim_stb_i || fire_extra) begin
        left_q <= left_d;
        nidx_q <= nidx_d;
      end
      if (prim_stb_i) begin
        gap_q <= gap_d;
      end
    end
  end

  assign out_stb_o = stb_q;
  assign out_idx_o = idx_q;
  assign overrun_o = ovr_q;

  // R4
  prim_idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prim_stb_i |=> (out_stb_o && (out_idx_o == '0)));

  // R6
  extra_not_adjacent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_stb_o && (out_idx_o != '0)) |-> !$past(out_stb_o));

  // R8
  err_no_extra_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prim_stb_i && err_i) |=> (left_q == '0));

  // R9
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |=> overrun_o);

  // R9
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prim_stb_i && pending) |=> overrun_o);

endmodule

// File: rtl/ispace_sched.sv
module ispace_sched
  import ispace_pkg::*;
#(
  parameter int SPACE_W   = 8,
  parameter int IDX_W     = 2,
  parameter int MIN_SPACE = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prim_stb_i,
  input  logic               cfg_bypass_i,
  input  logic [2:0]         cfg_mode_i,
  input  logic [SPACE_W-1:0] cfg_space_i,
  output logic               out_stb_o,
  output logic [IDX_W-1:0]   out_idx_o,
  output logic [2:0]         ifactor_o,
  output logic               cfg_err_o,
  output logic               overrun_o
);

  ifac_e              dec_ifac;
  logic               dec_mode_bad;
  logic               dec_space_bad;

  ifac_e              ifac_q, ifac_d;
  logic               err_q, err_d;
  logic [SPACE_W-1:0] space_q, space_d;

  logic               tmr_load;
  logic [SPACE_W-1:0] tmr_val;
  logic               tmr_run;
  logic               tmr_zero;
  logic [IDX_W-1:0]   extras;

  ispace_cfg_dec #(
    .SPACE_W   (SPACE_W),
    .MIN_SPACE (MIN_SPACE)
  ) u_dec (
    .bypass_i    (cfg_bypass_i),
    .mode_i      (cfg_mode_i),
    .space_i     (cfg_space_i),
    .ifac_o      (dec_ifac),
    .mode_bad_o  (dec_mode_bad),
    .space_bad_o (dec_space_bad)
  );

  always_comb begin
    ifac_d  = dec_ifac;
    err_d   = dec_mode_bad | dec_space_bad;
    space_d = cfg_space_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ifac_q  <= IFAC_1;
      err_q   <= 1'b0;
      space_q <= '0;
    end else begin
      ifac_q  <= ifac_d;
      err_q   <= err_d;
      space_q <= space_d;
    end
  end

  assign extras = IDX_W'(extras_of(ifac_q));

  ispace_burst_ctrl #(
    .SPACE_W (SPACE_W),
    .IDX_W   (IDX_W)
  ) u_burst (
    .clk        (clk),
    .rst_n      (rst_n),
    .prim_stb_i (prim_stb_i),
    .extras_i   (extras),
    .err_i      (err_q),
    .space_i    (space_q),
    .gap_zero_i (tmr_zero),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .tmr_run_o  (tmr_run),
    .out_stb_o  (out_stb_o),
    .out_idx_o  (out_idx_o),
    .overrun_o  (overrun_o)
  );

  ispace_gap_timer #(
    .W (SPACE_W)
  ) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .run_i      (tmr_run),
    .zero_o     (tmr_zero)
  );

  assign ifactor_o = ratio_of(ifac_q);
  assign cfg_err_o = err_q;

  // R3
  ratio_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ifactor_o) == 1);

  // R2
  bypass_unity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bypass_i |=> (ifactor_o == 3'd1));

  // R7
  small_space_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_space_i < SPACE_W'(MIN_SPACE)) |=> cfg_err_o);

endmodule

// File: tb/ispace_sched_tb.sv
module ispace_sched_tb;

  logic       clk;
  logic       rst_n;
  logic       prim;
  logic       byp;
  logic [2:0] mode;
  logic [7:0] space;
  logic       out_stb;
  logic [1:0] out_idx;
  logic [2:0] ifac;
  logic       err;
  logic       ovr;

  int checks   = 0;
  int failures = 0;
  int cyc      = 0;

  int ev_cyc [16];
  int ev_idx [16];
  int n_ev     = 0;

  ispace_sched u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .prim_stb_i   (prim),
    .cfg_bypass_i (byp),
    .cfg_mode_i   (mode),
    .cfg_space_i  (space),
    .out_stb_o    (out_stb),
    .out_idx_o    (out_idx),
    .ifactor_o    (ifac),
    .cfg_err_o    (err),
    .overrun_o    (ovr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (out_stb && n_ev < 16) begin
      ev_cyc[n_ev] = cyc;
      ev_idx[n_ev] = int'(out_idx);
      n_ev = n_ev + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input logic b, input logic [2:0] m, input logic [7:0] s);
    @(negedge clk);
    byp = b; mode = m; space = s;
    repeat (3) @(negedge clk);
    n_ev = 0;
  endtask

  task automatic pulse(output int t);
    @(negedge clk);
    t = cyc;
    prim = 1'b1;
    @(negedge clk);
    prim = 1'b0;
  endtask

  // Runs one burst and checks count, indices and timing of every output
  task automatic run_burst(input logic b, input logic [2:0] m, input logic [7:0] s,
                           input int exp_ratio, input bit exp_err, input int exp_n,
                           input string req);
    int t;
    int gap;
    set_cfg(b, m, s);
    chk(int'(ifac) == exp_ratio, req, "ratio", int'(ifac), exp_ratio);
    chk(err == exp_err, req, "cfg_err", int'(err), int'(exp_err));
    pulse(t);
    gap = int'(s) + 1;
    repeat (4 * gap + 8) @(negedge clk);
    chk(n_ev == exp_n, req, "output count", n_ev, exp_n);
    for (int k = 0; k < exp_n && k < n_ev; k++) begin
      chk(ev_idx[k] == k, req, "index", ev_idx[k], k);
      chk(ev_cyc[k] == t + 1 + k * gap, req, "timing", ev_cyc[k] - t, 1 + k * gap);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(out_stb == 1'b0, "R11", "out_stb after reset", int'(out_stb), 0);
    chk(out_idx == 2'd0, "R11", "out_idx after reset", int'(out_idx), 0);
    chk(ovr == 1'b0, "R11", "overrun after reset", int'(ovr), 0);
  endtask

  task automatic t_modes();
    run_burst(1'b1, 3'b010, 8'd6, 1, 1'b0, 1, "R2");
    run_burst(1'b1, 3'b000, 8'd6, 1, 1'b0, 1, "R2");
    run_burst(1'b0, 3'b001, 8'd6, 1, 1'b0, 1, "R3");
    run_burst(1'b0, 3'b010, 8'd5, 2, 1'b0, 2, "R5");
    run_burst(1'b0, 3'b011, 8'd9, 2, 1'b0, 2, "R6");
    run_burst(1'b0, 3'b111, 8'd2, 4, 1'b0, 4, "R5");
    run_burst(1'b0, 3'b110, 8'd255, 4, 1'b0, 4, "R6");
  endtask

  task automatic t_bad_cfg();
    run_burst(1'b0, 3'b000, 8'd6, 1, 1'b1, 1, "R1");
    run_burst(1'b0, 3'b100, 8'd6, 1, 1'b1, 1, "R1");
    run_burst(1'b0, 3'b101, 8'd6, 1, 1'b1, 1, "R1");
    run_burst(1'b0, 3'b111, 8'd1, 4, 1'b1, 1, "R7");
    run_burst(1'b0, 3'b011, 8'd0, 2, 1'b1, 1, "R8");
    run_burst(1'b1, 3'b001, 8'd1, 1, 1'b1, 1, "R7");
  endtask

  task automatic t_latch();
    int t;
    set_cfg(1'b0, 3'b011, 8'd4);
    pulse(t);
    space = 8'd20;
    repeat (30) @(negedge clk);
    chk(n_ev == 2, "R10", "output count", n_ev, 2);
    if (n_ev >= 2)
      chk(ev_cyc[1] == t + 6, "R10", "captured spacing", ev_cyc[1] - t, 6);
    chk(int'(ifac) == 2, "R10", "ratio", int'(ifac), 2);
  endtask

  task automatic t_overrun();
    int t1;
    int t2;
    int exp_c [6];
    int exp_i [6];
    set_cfg(1'b0, 3'b111, 8'd10);
    chk(ovr == 1'b0, "R9", "overrun before", int'(ovr), 0);
    pulse(t1);
    repeat (11) @(negedge clk);
    pulse(t2);
    repeat (60) @(negedge clk);
    exp_c[0] = t1 + 1;  exp_i[0] = 0;
    exp_c[1] = t1 + 12; exp_i[1] = 1;
    exp_c[2] = t2 + 1;  exp_i[2] = 0;
    exp_c[3] = t2 + 12; exp_i[3] = 1;
    exp_c[4] = t2 + 23; exp_i[4] = 2;
    exp_c[5] = t2 + 34; exp_i[5] = 3;
    chk(t2 == t1 + 13, "R9", "second strobe time", t2 - t1, 13);
    chk(n_ev == 6, "R9", "output count", n_ev, 6);
    for (int k = 0; k < 6 && k < n_ev; k++) begin
      chk(ev_idx[k] == exp_i[k], "R9", "index", ev_idx[k], exp_i[k]);
      chk(ev_cyc[k] == exp_c[k], "R9", "timing", ev_cyc[k] - t1, exp_c[k] - t1);
    end
    chk(ovr == 1'b1, "R9", "overrun set", int'(ovr), 1);
    set_cfg(1'b1, 3'b001, 8'd3);
    chk(ovr == 1'b1, "R9", "overrun sticky", int'(ovr), 1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ovr == 1'b0, "R11", "overrun cleared by reset", int'(ovr), 0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    wait (cyc > 150000);
    chk(1'b0, "WATCHDOG", "timeout", cyc, 150000);
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    prim  = 1'b0;
    byp   = 1'b1;
    mode  = 3'b001;
    space = 8'd10;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_modes();
    t_bad_cfg();
    t_latch();
    t_overrun();
    finish_run();
  end

endmodule